// File: doc/BRIEF.md
# Receive and transmit hardware handshake controller

This block runs the RTS/CTS handshake of a serial port in hardware, without any software action. It sits between the receive FIFO, the character transmitter and the modem control pins. On the transmit side it samples the active-low clear-to-send input and grants the start of each new character only while the far end allows it. A character that is already being shifted out is never cut short.

On the receive side it compares the receive FIFO fill level with one of four trigger levels, chosen by a 2-bit code. For a 32-entry FIFO the levels are 8, 16, 24 and 28 entries. When the fill reaches the chosen level, the block raises a trigger interrupt. It drives the RTS pin inactive (logic 1) only when the fill reaches the next level up, so the far end still has room to finish sending. It drives RTS active again only after the fill has drained below the next level down. Two enable inputs switch the transmit half and the receive half on independently. When automatic RTS is off, the pin carries the value written by software.

Top module: `uart_autoflow`

## Requirements
- R1: After reset both automatic functions are off. The trigger interrupt is 0, `rts_pin` equals `sw_rts`, and `tx_start` equals `tx_req & ~tx_busy`.
- R2: With `auto_cts_en`=1, `tx_start` is 0 in the cycle after a clock edge that sampled `cts_n`=1. It again follows `tx_req & ~tx_busy` in the cycle after an edge that sampled `cts_n`=0.
- R3: `tx_start` is 0 whenever `tx_busy`=1, so a new character starts only at a character boundary.
- R4: With `auto_cts_en`=0, `cts_n` has no effect on `tx_start`.
- R5: `trig_sel` codes 0, 1, 2 and 3 select trigger levels 8, 16, 24 and 28. With `auto_rts_en`=1, `trig_irq` is 1 in the cycle after an edge that sampled `rx_level` >= trigger, and 0 after an edge that sampled `rx_level` < trigger.
- R6: With `auto_rts_en`=1, `rts_pin` goes to 1 after an edge that sampled `rx_level` at or above the next level up. The next level up is 16, 24, 28 and 28 for codes 0 to 3.
- R7: With `auto_rts_en`=1, `rts_pin` returns to 0 after an edge that sampled `rx_level` below the next level down. The next level down is 8, 16 and 24 for codes 1 to 3. For code 0 this means the FIFO must be empty (`rx_level`=0).
- R8: While `rx_level` lies between the two thresholds, `rts_pin` keeps its previous value (hysteresis).
- R9: With `auto_rts_en`=0, `rts_pin` equals `sw_rts` in the same cycle, `trig_irq` is 0, and the RTS hold flag is cleared. A later enable with the fill inside the band therefore gives `rts_pin`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_cts_en | input | 1 | Enable transmit gating by CTS |
| auto_rts_en | input | 1 | Enable automatic RTS and the trigger interrupt |
| trig_sel | input | 2 | Trigger level code |
| rx_level | input | 6 | Receive FIFO fill level, 0 to 32 |
| sw_rts | input | 1 | Software RTS pin value |
| cts_n | input | 1 | Clear-to-send pin, active low |
| tx_req | input | 1 | Transmitter holds a character ready |
| tx_busy | input | 1 | A character is being shifted out |
| tx_start | output | 1 | Permission to issue a start bit now |
| rts_pin | output | 1 | RTS pin level, 1 = stop sending |
| trig_irq | output | 1 | Receive trigger interrupt request |

## Verification
A wrong RTS hold flag shows at `rts_pin` one cycle after the fill crosses a threshold. The sign is either a deassertion one trigger step early or late, or a release while the fill is still inside the hysteresis band. A stale CTS sample shows as a `tx_start` grant or block lasting one cycle too long after `cts_n` changes. The bench ramps the fill level up and then down for every trigger code, and sweeps every combination of the transmit inputs, so each such error appears within a single step.

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int DEPTH = 32,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_cts_en,
  input  logic          auto_rts_en,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          sw_rts,
  input  logic          cts_n,
  input  logic          tx_req,
  input  logic          tx_busy,
  output logic          tx_start,
  output logic          rts_pin,
  output logic          trig_irq
);
  localparam logic [LW-1:0] L0 = LW'(DEPTH / 4);
  localparam logic [LW-1:0] L1 = LW'(DEPTH / 2);
  localparam logic [LW-1:0] L2 = LW'((3 * DEPTH) / 4);
  localparam logic [LW-1:0] L3 = LW'(DEPTH - DEPTH / 8);

  logic          cts_q, stop_q, irq_q;
  logic [LW-1:0] trig, hi, lo;
  logic          release_ok;

  always_comb begin
    case (trig_sel)
      2'd0:    begin trig = L0; hi = L1; lo = '0; end
      2'd1:    begin trig = L1; hi = L2; lo = L0; end
      2'd2:    begin trig = L2; hi = L3; lo = L1; end
      default: begin trig = L3; hi = L3; lo = L2; end
    endcase
  end

  assign release_ok = (trig_sel == 2'd0) ? (rx_level == '0) : (rx_level < lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q  <= 1'b0;
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cts_q <= cts_n;
      irq_q <= auto_rts_en && (rx_level >= trig);
      if (!auto_rts_en)          stop_q <= 1'b0;
      else if (rx_level >= hi)   stop_q <= 1'b1;
      else if (release_ok)       stop_q <= 1'b0;
    end
  end

  assign tx_start = tx_req && !tx_busy && !(auto_cts_en && cts_q);
  assign rts_pin  = auto_rts_en ? stop_q : sw_rts;
  assign trig_irq = irq_q;

  assert_cts_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(cts_n)) |-> !tx_start);

  assert_rts_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> ($past(rx_level) >= $past(hi)));

  assert_hold_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(auto_rts_en) && $past(rx_level) < $past(hi) && !$past(release_ok)) |-> $stable(stop_q));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> ($past(rx_level) >= $past(trig)));

  assert_busy_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_start);
endmodule

// File: tb/tb_uart_autoflow.sv
module tb_uart_autoflow;
  logic clk = 0, rst_n = 0;
  logic auto_cts_en = 0, auto_rts_en = 0, sw_rts = 0, cts_n = 0, tx_req = 0, tx_busy = 0;
  logic [1:0] trig_sel = 0;
  logic [5:0] rx_level = 0;
  logic tx_start, rts_pin, trig_irq;
  int nvec = 0, nbad = 0;
  logic exp_stop;

  always #5 clk = ~clk;

  uart_autoflow dut (.*);

  task automatic check(input logic got, input logic exp, input string tag);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic int trig_of(int c); return (c == 3) ? 28 : 8 * (c + 1); endfunction
  function automatic int hi_of(int c);   return (c >= 2) ? 28 : 8 * (c + 2); endfunction
  function automatic int lo_of(int c);   return (c == 3) ? 24 : 8 * c; endfunction

  task automatic step_level(int c, int lv);
    @(negedge clk);
    trig_sel = 2'(c); rx_level = 6'(lv);
    @(posedge clk); #1;
    if (lv >= hi_of(c)) exp_stop = 1;
    else if ((c == 0) ? (lv == 0) : (lv < lo_of(c))) exp_stop = 0;
    check(rts_pin, exp_stop, "R6/R7/R8 rts_pin");
    check(trig_irq, lv >= trig_of(c), "R5 trig_irq");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(trig_irq, 0, "R1 irq reset");
        check(rts_pin, 0, "R1 rts reset");
        sw_rts = 1; #1 check(rts_pin, 1, "R1 rts follows sw");
        tx_req = 1; #1 check(tx_start, 1, "R1 tx_start reset");
        rst_n = 1;
        // transmit side sweep: R2 R3 R4
        for (int v = 0; v < 16; v++) begin
          @(negedge clk);
          {auto_cts_en, cts_n, tx_req, tx_busy} = 4'(v);
          @(posedge clk); #1;
          check(tx_start, tx_req & ~tx_busy & ~(auto_cts_en & cts_n),
                tx_busy ? "R3 busy gate" : (auto_cts_en ? "R2 cts gate" : "R4 cts ignored"));
        end
        @(negedge clk); auto_cts_en = 1; cts_n = 1; tx_req = 1; tx_busy = 0;
        @(posedge clk); #1 check(tx_start, 0, "R2 cts high blocks");
        @(negedge clk); cts_n = 0; #1 check(tx_start, 0, "R2 old sample still blocks");
        @(posedge clk); #1 check(tx_start, 1, "R2 resume");
        // receive side ramps: R5 R6 R7 R8
        @(negedge clk); auto_rts_en = 1; rx_level = 0; exp_stop = 0;
        for (int c = 0; c < 4; c++) begin
          for (int lv = 0; lv <= 32; lv++) step_level(c, lv);
          for (int lv = 32; lv >= 0; lv--) step_level(c, lv);
        end
        // R9: disabled follows software, clears the flag
        step_level(1, 30);
        @(negedge clk); auto_rts_en = 0; sw_rts = 0; #1 check(rts_pin, 0, "R9 sw 0");
        sw_rts = 1; #1 check(rts_pin, 1, "R9 sw 1");
        @(posedge clk); #1 check(trig_irq, 0, "R9 irq off");
        @(negedge clk); rx_level = 20; auto_rts_en = 1;
        @(posedge clk); #1 check(rts_pin, 0, "R9 flag cleared, R8 band hold");
      end
      begin
        repeat (20000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule